// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a word-addressed static memory with a fully registered interface. Address, control and write data are captured on the rising clock edge, the array is accessed one edge later, and read data leaves through an output register, so a read returns its word two edges after the edge that captured its address. The word is split into four byte lanes of 8 bits, or 9 bits when a parity bit rides with each lane. Shared data pins are modelled as a separate write bus, a read bus and a read-valid flag. The read bus is driven to zero whenever the valid flag is low, which stands for a floating bus.

An access sequence starts when either of two address strobes loads an external address while the chip is selected. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write enables. After that, an advance input steps a 2-bit burst counter over the two low address bits, in linear or interleaved order chosen by a mode pin. A snooze input freezes the block without losing its contents, and an output enable gates the read bus without waiting for a clock.

Top module: `pipe_burst_sram`

## Requirements
- R1: A read whose address is captured at clock edge k drives its word on `rdData` with `rdValid` high after edge k+2, provided `outEn` is high.
- R2: With `interleaveMode` low, each advance step adds 1 modulo 4 to the two low address bits of the loaded address (loaded 2 gives 2,3,0,1). The upper bits stay unchanged.
- R3: With `interleaveMode` high, beat n of a burst uses the loaded two low bits XOR n (loaded 1 gives 1,0,3,2).
- R4: While the chip is selected, a rising edge with `strobeCpu` or `strobeCtl` high loads `addrIn` and restarts the burst. A load by `strobeCpu` is always a read. Any write enables are ignored, including when `strobeCtl` is high in the same cycle.
- R5: When `globalWrEn` is high, an access writes all four lanes, whatever `byteWrEn` and `laneEn` hold.
- R6: When `globalWrEn` is low, lane i (bits i*8+7..i*8 for 8-bit lanes) is written only when both `byteWrEn` and `laneEn[i]` are high. With `byteWrEn` low, the access is a read.
- R7: The chip counts as selected only when `chipEn0`=1, `chipEn1N`=0 and `chipEn2`=1. A strobe edge while not selected ends the current sequence at once, and later advance or idle cycles make no access until the next selected strobe.
- R8: While a sequence is active, a cycle with neither strobe nor advance repeats the access at the current burst address.
- R9: `outEn` low forces `rdValid` and `rdData` to zero at once, with no clock edge needed. Raising it again shows the registered word.
- R10: While `snooze` is high, strobes, advances and writes have no effect. Stored words keep their values.
- R11: During and after reset, `rdValid` and `rdData` are zero, and no access takes place until a selected strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| addrIn | input | ADDR_W | Word address loaded by a strobe |
| strobeCpu | input | 1 | Processor-side address strobe, always starts a read |
| strobeCtl | input | 1 | Controller-side address strobe, starts a read or a write |
| advance | input | 1 | Steps the burst counter |
| interleaveMode | input | 1 | 0 = linear burst order, 1 = interleaved |
| chipEn0 | input | 1 | Chip enable, active high |
| chipEn1N | input | 1 | Chip enable, active low |
| chipEn2 | input | 1 | Chip enable, active high |
| laneEn | input | 4 | Per-lane write enables |
| byteWrEn | input | 1 | Qualifies `laneEn` |
| globalWrEn | input | 1 | Writes every lane |
| snooze | input | 1 | Low-power hold, accesses ignored |
| outEn | input | 1 | Asynchronous gate on the read bus |
| wrData | input | DATA_W | Write data, captured with the address |
| rdData | output | DATA_W | Registered read data, zero when not valid |
| rdValid | output | 1 | Read bus carries a word |

## Verification
Several decisions can land in the same cycle. The most telling case is a processor strobe that arrives while the write enables are active and the controller strobe is also high, because both a read and a write are then requested. The bench provokes this twice: once with a full-word write pattern in the linear burst vector table, and once with both strobes raised together. The bench then reads the word back later, and the word is correct only if the read won and the array stayed unchanged. A second overlap is an output-enable drop while a registered read word is on the bus. The bench judges this between clock edges, by checking that the bus clears and then comes back without any edge.

// File: rtl/pbs_pkg.sv
`timescale 1ns/1ps
package pbs_pkg;
  localparam int LANES = 4;

  typedef enum logic {
    BURST_LINEAR     = 1'b0,
    BURST_INTERLEAVE = 1'b1
  } burstOrder_e;

  typedef struct packed {
    logic             doRead;
    logic             doWrite;
    logic [LANES-1:0] laneWr;
  } sramCmd_t;
endpackage

// File: rtl/pbs_burst.sv
`timescale 1ns/1ps
module pbs_burst
  import pbs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        load,
  input  logic        step,
  input  burstOrder_e order,
  input  logic [1:0]  loadBits,
  output logic [1:0]  beatBits
);
  logic [1:0] baseQ, cntQ, baseNext, cntNext;

  always_comb begin
    baseNext = load ? loadBits : baseQ;
    if (load)      cntNext = 2'd0;
    else if (step) cntNext = cntQ + 2'd1;
    else           cntNext = cntQ;
    if (order == BURST_INTERLEAVE) beatBits = baseNext ^ cntNext;
    else                           beatBits = baseNext + cntNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= 2'd0;
      cntQ  <= 2'd0;
    end else begin
      baseQ <= baseNext;
      cntQ  <= cntNext;
    end
  end
endmodule

// File: rtl/pbs_ctrl.sv
`timescale 1ns/1ps
module pbs_ctrl
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              strobeCpu,
  input  logic              strobeCtl,
  input  logic              advance,
  input  burstOrder_e       order,
  input  logic              chipEn0,
  input  logic              chipEn1N,
  input  logic              chipEn2,
  input  logic [LANES-1:0]  laneEn,
  input  logic              byteWrEn,
  input  logic              globalWrEn,
  input  logic              snooze,
  output sramCmd_t          cmd,
  output logic [ADDR_W-1:0] accAddr
);
  localparam int UPPER_W = ADDR_W - 2;

  logic               chipSel, anyStrobe, loadHit, stepHit, holdHit, accessNow;
  logic               activeQ, wrNow;
  logic [UPPER_W-1:0] upperQ, upperNext;
  logic [1:0]         beatBits;
  logic [LANES-1:0]   lanesNow;
  sramCmd_t           cmdQ;
  logic [ADDR_W-1:0]  addrQ;

  always_comb begin
    chipSel   = chipEn0 & ~chipEn1N & chipEn2;
    anyStrobe = (strobeCpu | strobeCtl) & ~snooze;
    loadHit   = anyStrobe & chipSel;
    stepHit   = ~snooze & ~anyStrobe & activeQ & advance;
    holdHit   = ~snooze & ~anyStrobe & activeQ & ~advance;
    accessNow = loadHit | stepHit | holdHit;
    upperNext = loadHit ? addrIn[ADDR_W-1:2] : upperQ;
    if (globalWrEn)    lanesNow = '1;
    else if (byteWrEn) lanesNow = laneEn;
    else               lanesNow = '0;
    wrNow = accessNow & ~(loadHit & strobeCpu) & (|lanesNow);
  end

  pbs_burst u_burst (
    .clk      (clk),
    .rstN     (rstN),
    .load     (loadHit),
    .step     (stepHit),
    .order    (order),
    .loadBits (addrIn[1:0]),
    .beatBits (beatBits)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      upperQ  <= '0;
      cmdQ    <= '0;
      addrQ   <= '0;
    end else begin
      if (anyStrobe) activeQ <= chipSel;
      upperQ       <= upperNext;
      cmdQ.doRead  <= accessNow & ~wrNow;
      cmdQ.doWrite <= wrNow;
      cmdQ.laneWr  <= wrNow ? lanesNow : '0;
      if (accessNow) addrQ <= {upperNext, beatBits};
    end
  end

  assign cmd     = cmdQ;
  assign accAddr = addrQ;
endmodule

// File: rtl/pbs_datapath.sv
`timescale 1ns/1ps
module pbs_datapath
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  sramCmd_t          cmd,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              outEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [DATA_W-1:0] wdQ, arrayQ, outQ;
  logic              rdPend, outValid;

  always_ff @(posedge clk) wdQ <= wrData;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneQ;
    always_ff @(posedge clk) begin
      if (cmd.doWrite && cmd.laneWr[g]) laneMem[accAddr] <= wdQ[g*LANE_W +: LANE_W];
      if (cmd.doRead) laneQ <= laneMem[accAddr];
    end
    assign arrayQ[g*LANE_W +: LANE_W] = laneQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPend   <= 1'b0;
      outValid <= 1'b0;
      outQ     <= '0;
    end else begin
      rdPend   <= cmd.doRead;
      outValid <= rdPend;
      if (rdPend) outQ <= arrayQ;
    end
  end

  assign rdValid = outValid & outEn;
  assign rdData  = rdValid ? outQ : '0;
endmodule

// File: rtl/pipe_burst_sram.sv
`timescale 1ns/1ps
module pipe_burst_sram
  import pbs_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter bit HAS_PARITY = 1'b0,
  localparam int LANE_W = HAS_PARITY ? 9 : 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              strobeCpu,
  input  logic              strobeCtl,
  input  logic              advance,
  input  logic              interleaveMode,
  input  logic              chipEn0,
  input  logic              chipEn1N,
  input  logic              chipEn2,
  input  logic [LANES-1:0]  laneEn,
  input  logic              byteWrEn,
  input  logic              globalWrEn,
  input  logic              snooze,
  input  logic              outEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  sramCmd_t          cmdBus;
  logic [ADDR_W-1:0] accAddr;

  pbs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .addrIn     (addrIn),
    .strobeCpu  (strobeCpu),
    .strobeCtl  (strobeCtl),
    .advance    (advance),
    .order      (burstOrder_e'(interleaveMode)),
    .chipEn0    (chipEn0),
    .chipEn1N   (chipEn1N),
    .chipEn2    (chipEn2),
    .laneEn     (laneEn),
    .byteWrEn   (byteWrEn),
    .globalWrEn (globalWrEn),
    .snooze     (snooze),
    .cmd        (cmdBus),
    .accAddr    (accAddr)
  );

  pbs_datapath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmdBus),
    .accAddr (accAddr),
    .wrData  (wrData),
    .outEn   (outEn),
    .rdData  (rdData),
    .rdValid (rdValid)
  );
endmodule

// File: rtl/pbs_checker.sv
`timescale 1ns/1ps
module pbs_checker
  import pbs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              strobeCpu,
  input logic              strobeCtl,
  input logic              chipEn0,
  input logic              chipEn1N,
  input logic              chipEn2,
  input logic              snooze,
  input logic              outEn,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input sramCmd_t          cmd
);
  logic selNow;
  assign selNow = chipEn0 & ~chipEn1N & chipEn2;

  assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    cmd.doRead |-> ##2 (rdValid || !outEn));

  assert_cpu_reads_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobeCpu && selNow && !snooze) |-> (cmd.doRead && !cmd.doWrite));

  assert_rw_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.doRead && cmd.doWrite));

  assert_lanes_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.doWrite |-> (cmd.laneWr == '0));

  assert_deselect_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past((strobeCpu || strobeCtl) && !selNow && !snooze) |-> !(cmd.doRead || cmd.doWrite));

  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> !rdValid);

  assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));

  assert_snooze_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(snooze) |-> !(cmd.doRead || cmd.doWrite));
endmodule

bind pipe_burst_sram pbs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .strobeCpu (strobeCpu),
  .strobeCtl (strobeCtl),
  .chipEn0   (chipEn0),
  .chipEn1N  (chipEn1N),
  .chipEn2   (chipEn2),
  .snooze    (snooze),
  .outEn     (outEn),
  .rdData    (rdData),
  .rdValid   (rdValid),
  .cmd       (cmdBus)
);

// File: tb/sim_pipe_burst_sram.sv
`timescale 1ns/1ps
module sim_pipe_burst_sram;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  addrIn = '0;
  logic        strobeCpu = 0, strobeCtl = 0, advance = 0, interleaveMode = 0;
  logic        chipEn0 = 1, chipEn1N = 0, chipEn2 = 1;
  logic [3:0]  laneEn = '0;
  logic        byteWrEn = 0, globalWrEn = 0, snooze = 0, outEn = 1;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        rdValid;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pipe_burst_sram u0 (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .strobeCpu(strobeCpu), .strobeCtl(strobeCtl),
    .advance(advance), .interleaveMode(interleaveMode), .chipEn0(chipEn0), .chipEn1N(chipEn1N),
    .chipEn2(chipEn2), .laneEn(laneEn), .byteWrEn(byteWrEn), .globalWrEn(globalWrEn),
    .snooze(snooze), .outEn(outEn), .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  typedef struct packed {
    logic        cpu;
    logic        ctl;
    logic        adv;
    logic        wr;
    logic        sel;
    logic [9:0]  addr;
    logic [31:0] data;
    logic        expV;
    logic [31:0] expD;
  } vec_t;

  // expV/expD: bus state observed before the vector is applied (result of vector i-3)
  localparam vec_t VECS [15] = '{
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 10'h010, 32'hC0DE0010, 1'b0, 32'h0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'h000, 32'hC0DE0011, 1'b0, 32'h0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'h000, 32'hC0DE0012, 1'b0, 32'h0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 10'h000, 32'hC0DE0013, 1'b0, 32'h0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 10'h012, 32'hFFFFFFFF, 1'b0, 32'h0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 10'h000, 32'h0,        1'b0, 32'h0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 10'h000, 32'h0,        1'b0, 32'h0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 10'h000, 32'h0,        1'b1, 32'hC0DE0012},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 10'h000, 32'h0,        1'b1, 32'hC0DE0013},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'h000, 32'h0,        1'b1, 32'hC0DE0010},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'h000, 32'h0,        1'b1, 32'hC0DE0011},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 10'h000, 32'h0,        1'b1, 32'hC0DE0012},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'h000, 32'h0,        1'b1, 32'hC0DE0012},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'h000, 32'h0,        1'b0, 32'h0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'h000, 32'h0,        1'b0, 32'h0}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expectBus(string tag, logic expV, logic [31:0] expD);
    checks++;
    if (rdValid !== expV || rdData !== expD) begin
      errors++;
      $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
               tag, rdValid, rdData, expV, expD);
    end
  endtask

  task automatic drive(logic cpu, logic ctl, logic adv, logic gw, logic bw, logic [3:0] lanes,
                       logic sel, logic [9:0] addr, logic [31:0] data);
    strobeCpu = cpu; strobeCtl = ctl; advance = adv; globalWrEn = gw; byteWrEn = bw;
    laneEn = lanes; chipEn0 = sel; addrIn = addr; wrData = data;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 4'h0, 1, 10'h0, 32'h0);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finishRun();
  end

  initial begin
    // R11: reset state
    repeat (3) tick();
    expectBus("R11 in reset", 0, 32'h0);
    rstN = 1'b1;
    tick(); tick();
    expectBus("R11 after reset", 0, 32'h0);

    // Table: linear burst (R2), latency (R1), cpu strobe ignores writes (R4),
    // hold repeats (R8), deselect and advance while inactive (R7)
    for (int i = 0; i < 15; i++) begin
      expectBus($sformatf("R1/R2/R4/R7/R8 vector %0d", i), VECS[i].expV, VECS[i].expD);
      drive(VECS[i].cpu, VECS[i].ctl, VECS[i].adv, VECS[i].wr, 0, 4'h0,
            VECS[i].sel, VECS[i].addr, VECS[i].data);
      tick();
    end
    idle();

    // R3: interleaved burst from loaded low bits 01 -> 1,0,3,2
    interleaveMode = 1'b1;
    drive(1, 0, 0, 0, 0, 4'h0, 1, 10'h011, 32'h0); tick();
    drive(0, 0, 1, 0, 0, 4'h0, 1, 10'h0, 32'h0);   tick();
    drive(0, 0, 1, 0, 0, 4'h0, 1, 10'h0, 32'h0);   tick();
    expectBus("R3 beat0", 1, 32'hC0DE0011);
    drive(0, 0, 1, 0, 0, 4'h0, 1, 10'h0, 32'h0);   tick();
    expectBus("R3 beat1", 1, 32'hC0DE0010);
    drive(0, 1, 0, 0, 0, 4'h0, 0, 10'h0, 32'h0);   tick();
    expectBus("R3 beat2", 1, 32'hC0DE0013);
    idle(); tick();
    expectBus("R3 beat3", 1, 32'hC0DE0012);
    tick();
    expectBus("R7 deselect after interleave", 0, 32'h0);
    interleaveMode = 1'b0;

    // R6: lane writes 0 and 2 over 11223344 -> 11FF33FF; byteWrEn low writes nothing
    drive(0, 1, 0, 1, 0, 4'h0, 1, 10'h030, 32'h11223344); tick();
    drive(0, 1, 0, 0, 1, 4'b0101, 1, 10'h030, 32'hFFFFFFFF); tick();
    drive(0, 1, 0, 0, 0, 4'b1111, 1, 10'h030, 32'h00000000); tick();
    expectBus("R6 full write gives no read data", 0, 32'h0);
    drive(0, 1, 0, 0, 0, 4'h0, 0, 10'h0, 32'h0); tick();
    expectBus("R6 lane write gives no read data", 0, 32'h0);
    idle(); tick();
    expectBus("R6 lanes 0,2 only, byteWrEn low ignored", 1, 32'h11FF33FF);
    tick();
    expectBus("R7 idle after deselect", 0, 32'h0);

    // R5: global write overrides lane mask 0001
    drive(0, 1, 0, 1, 1, 4'b0001, 1, 10'h031, 32'hCAFEBABE); tick();
    drive(1, 0, 0, 0, 0, 4'h0, 1, 10'h031, 32'h0); tick();
    drive(0, 1, 0, 0, 0, 4'h0, 0, 10'h0, 32'h0); tick();
    expectBus("R5 write slot", 0, 32'h0);
    idle(); tick();
    expectBus("R5 global write all lanes", 1, 32'hCAFEBABE);

    // R9: asynchronous output enable, no clock edge in between
    #1 outEn = 1'b0;
    #1 expectBus("R9 outEn low clears bus", 0, 32'h0);
    outEn = 1'b1;
    #1 expectBus("R9 outEn high restores word", 1, 32'hCAFEBABE);

    // R4: both strobes with full write -> read, word unchanged
    tick();
    drive(1, 1, 0, 1, 0, 4'h0, 1, 10'h030, 32'h0); tick();
    drive(0, 1, 0, 0, 0, 4'h0, 0, 10'h0, 32'h0);   tick();
    idle(); tick();
    expectBus("R4 processor strobe wins, reads", 1, 32'h11FF33FF);
    tick();

    // R10: snooze ignores a write strobe, contents retained
    snooze = 1'b1;
    drive(0, 1, 0, 1, 0, 4'h0, 1, 10'h031, 32'h0); tick();
    idle(); tick();
    snooze = 1'b0;
    drive(1, 0, 0, 0, 0, 4'h0, 1, 10'h031, 32'h0); tick();
    expectBus("R10 snooze no access", 0, 32'h0);
    drive(0, 1, 0, 0, 0, 4'h0, 0, 10'h0, 32'h0); tick();
    expectBus("R10 snooze no access 2", 0, 32'h0);
    idle(); tick();
    expectBus("R10 word retained through snooze", 1, 32'hCAFEBABE);
    tick();
    expectBus("R7 quiet after final deselect", 0, 32'h0);

    finishRun();
  end
endmodule